// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Unit

This unit sits beside a single-port synchronous memory and performs an indivisible read, compare and conditional write on one naturally aligned location of 1, 2, 4 or 8 bytes. A requester hands it an address, an operand size, an expected value and a replacement value. The unit reads the 64-bit memory word that holds the operand and compares the addressed bytes with the expected value. If they match, it writes the replacement into those bytes only. If they differ, no store takes place and the observed bytes are returned in place of the expected value.

While the sequence runs, a lock output tells the surrounding fabric to keep every other agent away from memory. A zero flag reports the outcome: set when the store was committed, clear when the location held something else. A single-cycle done strobe closes each operation. For the 8-byte form, the expected value and the replacement are each supplied as a high and low 32-bit half.

Top module: `cas_unit`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the cycle after `done`, so it is low in the `done` cycle itself, and `done` is a one-cycle pulse.
- R2: When the addressed bytes of the memory word equal the low bytes of the expected value, the unit writes the replacement into exactly those bytes and reports `zf` = 1.
- R3: When the addressed bytes differ from the expected value, the unit issues no write and reports `zf` = 0. `acc_hi:acc_lo` then holds the observed memory bytes in its low operand-sized part, and the expected-value input bits above the operand size are left unchanged.
- R4: On success, `acc_hi:acc_lo` equals the expected value as given, all 64 bits.
- R5: With size code 3, the compare uses `req_acc_hi:req_acc_lo` as one 64-bit value, and the store uses `req_new_hi:req_new_lo`, with the high half in memory bits 63:32.
- R6: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The byte offset `req_addr[2:0]` is rounded down to a multiple of the size. Byte k of the operand maps to memory byte lane offset+k, and `mem_be` bit n enables lane n (bits 8n+7:8n). Only the enabled lanes are written.
- R7: `mem_lock` is high in the read cycle, the compare cycle and, on success, the write cycle. It is low in the `done` cycle, and every memory access is made with `mem_lock` high.
- R8: The read is issued in the first cycle after acceptance. `done` rises in the third cycle after acceptance on a mismatch and in the fourth on a match. A write is always issued two cycles after a read.
- R9: After reset, `req_ready` is 1, and `done`, `zf`, `mem_req`, `mem_lock` and `acc_hi:acc_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code (0..3 = 1, 2, 4, 8 bytes) |
| req_acc_hi | input | 32 | Expected value, high half |
| req_acc_lo | input | 32 | Expected value, low half |
| req_new_hi | input | 32 | Replacement value, high half |
| req_new_lo | input | 32 | Replacement value, low half |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_be | output | 8 | Byte lane enables for writes |
| mem_wdata | output | 64 | Write data, lane aligned |
| mem_rdata | input | 64 | Read data, valid the cycle after a read |
| mem_lock | output | 1 | Hold off other memory agents |
| done | output | 1 | Operation complete pulse |
| zf | output | 1 | 1 = store committed, 0 = mismatch |
| acc_hi | output | 32 | Resulting accumulator, high half |
| acc_lo | output | 32 | Resulting accumulator, low half |

## Verification
The `done` pulse of one operation and the arrival of the next request fall in the same cycle whenever requests are issued back to back. The bench provokes this by raising the next request immediately after it sees `done`. It then judges that `req_ready` is low in that cycle and that the new read starts only one cycle after the return to idle. The release of the lock also coincides with the completion strobe. The bench counts the locked cycles of every operation, expecting two on a mismatch and three on a match, and requires the lock to be low while `done` is high.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } cas_state_e;
endpackage

// File: rtl/cas_rst_sync.sv
module cas_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cas_lane.sv
// Lane steering: picks the operand bytes out of a memory word, compares
// them, builds byte enables, aligned write data and the mismatch result.
module cas_lane #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]                   size,
  input  logic [$clog2(DATA_W/8)-1:0]  ofs,
  input  logic [DATA_W-1:0]            exp_val,
  input  logic [DATA_W-1:0]            new_val,
  input  logic [DATA_W-1:0]            rdata,
  output logic [DATA_W/8-1:0]          be,
  output logic [DATA_W-1:0]            wdata,
  output logic                         hit,
  output logic [DATA_W-1:0]            acc_merge
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);

  logic [OFS_W:0]       nbytes;
  logic [OFS_W-1:0]     base;
  logic [OFS_W+2:0]     bit_sh;
  logic [BYTES-1:0]     op_byte;
  logic [DATA_W-1:0]    op_mask;
  logic [DATA_W-1:0]    rd_op;

  always_comb begin
    nbytes = (OFS_W+1)'(1) << size;
    base   = ofs & ~(nbytes[OFS_W-1:0] - 1'b1);
    bit_sh = {base, 3'b000};
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign op_byte[b]          = ((OFS_W+1)'(b) < nbytes);
    assign op_mask[8*b +: 8]   = {8{op_byte[b]}};
  end

  assign be        = op_byte << base;
  assign wdata     = (new_val & op_mask) << bit_sh;
  assign rd_op     = (rdata >> bit_sh) & op_mask;
  assign hit       = (rd_op == (exp_val & op_mask));
  assign acc_merge = (exp_val & ~op_mask) | rd_op;
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  output logic ready,
  output logic rd_req,
  output logic wr_req,
  output logic lock,
  output logic cmp_en,
  output logic done
);
  cas_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_CMP;
      ST_CMP:   state_d = hit ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ready  = (state_q == ST_IDLE);
  assign rd_req = (state_q == ST_READ);
  assign wr_req = (state_q == ST_WRITE);
  assign cmp_en = (state_q == ST_CMP);
  assign lock   = rd_req | cmp_en | wr_req;
  assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/cas_unit.sv
module cas_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  req_size,
  input  logic [DATA_W/2-1:0]         req_acc_hi,
  input  logic [DATA_W/2-1:0]         req_acc_lo,
  input  logic [DATA_W/2-1:0]         req_new_hi,
  input  logic [DATA_W/2-1:0]         req_new_lo,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]         mem_be,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        mem_lock,
  output logic                        done,
  output logic                        zf,
  output logic [DATA_W/2-1:0]         acc_hi,
  output logic [DATA_W/2-1:0]         acc_lo
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);
  localparam int HALF  = DATA_W / 2;

  logic              rst_n_s;
  logic              accept, rd_req, wr_req, cmp_en, hit;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] exp_q, new_q, acc_q, acc_merge;
  logic              zf_q;
  logic [BYTES-1:0]  be;
  logic [DATA_W-1:0] wdata;

  cas_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  cas_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(accept), .hit(hit),
    .ready(req_ready), .rd_req(rd_req), .wr_req(wr_req),
    .lock(mem_lock), .cmp_en(cmp_en), .done(done)
  );

  cas_lane #(.DATA_W(DATA_W)) u_lane (
    .size(size_q), .ofs(addr_q[OFS_W-1:0]), .exp_val(exp_q), .new_val(new_q),
    .rdata(mem_rdata), .be(be), .wdata(wdata), .hit(hit), .acc_merge(acc_merge)
  );

  assign accept = req_valid & req_ready;

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '0;
      size_q <= '0;
      exp_q  <= '0;
      new_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      size_q <= req_size;
      exp_q  <= {req_acc_hi, req_acc_lo};
      new_q  <= {req_new_hi, req_new_lo};
    end
  end

  // result capture, enabled in the compare cycle
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      zf_q  <= 1'b0;
      acc_q <= '0;
    end else if (cmp_en) begin
      zf_q  <= hit;
      acc_q <= hit ? exp_q : acc_merge;
    end
  end

  assign mem_req   = rd_req | wr_req;
  assign mem_we    = wr_req;
  assign mem_addr  = addr_q[ADDR_W-1:OFS_W];
  assign mem_be    = wr_req ? be : '0;
  assign mem_wdata = wdata;
  assign zf        = zf_q;
  assign acc_hi    = acc_q[DATA_W-1:HALF];
  assign acc_lo    = acc_q[HALF-1:0];
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic mem_req,
  input logic mem_we,
  input logic mem_lock,
  input logic done,
  input logic zf
);
  // R7: no memory access outside the locked window
  a_r7_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  // R7: lock released in the completion cycle
  a_r7_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_lock);
  // R1: busy while completing, and done lasts one cycle
  a_r1_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: a store is followed by completion with the flag set
  a_r2_store_sets_zf: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (done && zf));
  // R3: a failed compare completes without a store just before
  a_r3_fail_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zf) |-> !$past(mem_req && mem_we));
  // R8: every store comes two cycles after a read
  a_r8_store_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));
endmodule

bind cas_unit cas_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_lock(mem_lock), .done(done), .zf(zf)
);

// File: tb/tb_cas_unit.sv
`timescale 1ns/1ps
module tb_cas_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_acc_hi, req_acc_lo, req_new_hi, req_new_lo;
  logic        mem_req, mem_we, mem_lock, done, zf;
  logic [12:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;
  logic [31:0] acc_hi, acc_lo;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [63:0] mem   [4];
  logic [63:0] shadow[4];

  always #2.5 clk = ~clk;

  cas_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .req_acc_hi(req_acc_hi), .req_acc_lo(req_acc_lo),
    .req_new_hi(req_new_hi), .req_new_lo(req_new_lo),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock),
    .done(done), .zf(zf), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  // single-port synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int n = 0; n < 8; n++)
          if (mem_be[n]) mem[mem_addr[1:0]][8*n +: 8] <= mem_wdata[8*n +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[1:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lane_base(input logic [2:0] ofs, input logic [1:0] size);
    int nb = 1 << size;
    return (int'(ofs) / nb) * nb;
  endfunction

  // expected outcome from the requirements
  function automatic void predict(input logic [63:0] word, input logic [15:0] addr,
      input logic [1:0] size, input logic [63:0] acc, input logic [63:0] nw,
      output bit eq, output logic [63:0] acc_exp, output logic [63:0] word_exp,
      output logic [7:0] be_exp);
    int nb = 1 << size;
    int bs = lane_base(addr[2:0], size);
    eq = 1'b1;
    acc_exp  = acc;
    word_exp = word;
    be_exp   = '0;
    for (int k = 0; k < nb; k++) begin
      if (word[8*(bs+k) +: 8] != acc[8*k +: 8]) eq = 1'b0;
      acc_exp[8*k +: 8] = word[8*(bs+k) +: 8];
      be_exp[bs+k] = 1'b1;
    end
    if (eq) begin
      acc_exp = acc;
      for (int k = 0; k < nb; k++) word_exp[8*(bs+k) +: 8] = nw[8*k +: 8];
    end
  endfunction

  task automatic run_op(input logic [15:0] addr, input logic [1:0] size,
                        input logic [63:0] acc, input logic [63:0] nw);
    bit eq;
    logic [63:0] acc_e, word_e;
    logic [7:0]  be_e, be_seen;
    int cyc, lk, wr;
    int idx = int'(addr[4:3]);
    predict(shadow[idx], addr, size, acc, nw, eq, acc_e, word_e, be_e);
    req_valid  = 1'b1;
    req_addr   = addr;
    req_size   = size;
    {req_acc_hi, req_acc_lo} = acc;
    {req_new_hi, req_new_lo} = nw;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; lk = 0; wr = 0; be_seen = '0;
    while (!done && cyc < 20) begin
      if (mem_lock) lk++;
      if (mem_req && mem_we) begin wr++; be_seen = mem_be; end
      @(negedge clk);
      cyc++;
    end
    chk(zf == eq, "R2/R3 zf", 64'(zf), 64'(eq));
    if (eq) chk({acc_hi, acc_lo} == acc_e, "R4 acc kept", {acc_hi, acc_lo}, acc_e);
    else    chk({acc_hi, acc_lo} == acc_e, "R3 acc loaded", {acc_hi, acc_lo}, acc_e);
    chk(cyc == (eq ? 4 : 3), "R8 latency", 64'(cyc), 64'(eq ? 4 : 3));
    chk(wr == (eq ? 1 : 0), "R2/R3 store count", 64'(wr), 64'(eq ? 1 : 0));
    if (eq) chk(be_seen == be_e, "R6 byte enables", 64'(be_seen), 64'(be_e));
    chk(lk == (eq ? 3 : 2), "R7 lock cycles", 64'(lk), 64'(eq ? 3 : 2));
    chk(!mem_lock && !req_ready, "R1/R7 done cycle", {62'd0, mem_lock, req_ready}, 64'd0);
    chk(mem[idx] == word_e, size == 2'd3 ? "R5 memory word" : "R6 memory word",
        mem[idx], word_e);
    shadow[idx] = word_e;
  endtask

  function automatic logic [63:0] match_acc(input logic [15:0] addr, input logic [1:0] size,
                                            input logic [63:0] fill);
    logic [63:0] a = fill;
    int nb = 1 << size;
    int bs = lane_base(addr[2:0], size);
    for (int k = 0; k < nb; k++) a[8*k +: 8] = shadow[int'(addr[4:3])][8*(bs+k) +: 8];
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_acc_hi = '0; req_acc_lo = '0; req_new_hi = '0; req_new_lo = '0;
    mem_rdata = '0;
    mem[0] = 64'h0123_4567_89AB_CDEF; mem[1] = 64'hFEDC_BA98_7654_3210;
    mem[2] = 64'h1111_2222_3333_4444; mem[3] = 64'hDEAD_BEEF_CAFE_F00D;
    for (int i = 0; i < 4; i++) shadow[i] = mem[i];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready && !done && !zf && !mem_req && !mem_lock && {acc_hi, acc_lo} == 64'd0,
        "R9 reset", {acc_hi, acc_lo}, 64'd0);

    // R2/R6: byte at highest lane, match
    run_op(16'h0007, 2'd0, 64'hAAAA_AAAA_AAAA_AA01, 64'h0000_0000_0000_005A);
    // R3: byte mismatch, upper acc bits kept
    run_op(16'h0000, 2'd0, 64'h1234_5678_9ABC_DE00, 64'h77);
    // R6: 16-bit at lane 6, match
    run_op(16'h000E, 2'd1, 64'h0000_0000_0000_FEDC, 64'h0000_0000_0000_B00B);
    // R6: misaligned 32-bit offset 5 rounds to lane 4
    run_op(16'h0015, 2'd2, 64'h0000_0000_1111_2222, 64'h0000_0000_5555_6666);
    // R5: 64-bit, only high half differs -> mismatch
    run_op(16'h0018, 2'd3, 64'h0000_0000_CAFE_F00D, 64'h0102_0304_0506_0708);
    // R5: 64-bit match via hi:lo pair
    run_op(16'h0018, 2'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'h0102_0304_0506_0708);
    // R1: back-to-back request raised right after done
    run_op(16'h0018, 2'd3, 64'h0102_0304_0506_0708, 64'h0);

    for (int t = 0; t < 300; t++) begin
      logic [15:0] a;
      logic [1:0]  s;
      logic [63:0] ac, nv;
      a  = {11'd0, 2'($urandom % 4), 3'($urandom % 8)};
      s  = 2'($urandom % 4);
      ac = {$urandom, $urandom};
      nv = {$urandom, $urandom};
      if ($urandom % 2) ac = match_acc(a, s, ac);
      run_op(a, s, ac, nv);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule